// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures an incoming signal in one of two ways. In frequency mode it counts rising edges of a chosen input over a fixed gate window. In period mode it counts system-clock cycles between two consecutive rising edges of the low-frequency input. A single saturating counter, 20 bits wide by default, holds the result in both modes. The gate window is built from a millisecond tick that is derived from the system clock.

Software first writes a configuration: the input, the mode and the window length. It then pulses `start`. `busy` stays high while the measurement runs. At the end, `busy` drops, `done` rises and `count` is frozen until the next start. The high-frequency input always goes through a divide-by-two prescaler before it reaches the counter. Both inputs are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops before edge detection.

Top module: `universal_counter`

## Requirements
- R1: After reset `busy`, `done`, `overflow` and `count` are all zero, and the configuration is frequency mode on the high-frequency input with a 1 ms window, so a `start` with no configuration write measures that input.
- R2: In frequency mode with `cfg_use_lf`=1, `count` equals the number of low-frequency rising edges detected during the window. The window is gate code 0=1 ms, 1=4 ms, 2=8 ms or 3=32 ms, each ms being `CLK_PER_MS` clock cycles from the start.
- R3: In frequency mode with `cfg_use_lf`=0, `count` equals the number of high-frequency rising edges in the window divided by two, rounded down, because the prescaler is cleared at each start.
- R4: In period mode (`cfg_period`=1), the low-frequency input is used whatever `cfg_use_lf` holds. The first rising edge arms the counter, and `count` then equals the number of clock cycles up to the next rising edge, where the measurement stops.
- R5: In period mode, if the window ends before the closing edge, the measurement stops with `done`=1 and `overflow`=1.
- R6: When a measurement ends, `busy` falls, `done` rises and `count` stays unchanged until the next `start`. `busy` and `done` are never high together.
- R7: The counter saturates at all ones (0xFFFFF at the default width). An increment requested at that value sets `overflow`, which stays set until the next `start`.
- R8: `start` is accepted even while busy. One cycle later `count` is zero, `done` and `overflow` are clear and `busy` is high.
- R9: A configuration write (`cfg_we`) while `busy` is high is ignored. A write while idle takes effect from the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_in | input | 1 | High-frequency measured input (asynchronous) |
| lf_in | input | 1 | Low-frequency measured input (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe, honoured only when idle |
| cfg_use_lf | input | 1 | 1 selects the low-frequency input for frequency mode |
| cfg_period | input | 1 | 1 selects period mode, 0 frequency mode |
| cfg_gate | input | 2 | Window code: 0=1 ms, 1=4 ms, 2=8 ms, 3=32 ms |
| start | input | 1 | Pulse that clears the result and begins a measurement |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Measurement finished, result held |
| overflow | output | 1 | Saturation or period timeout occurred |
| count | output | CNT_W | Measurement result |

## Verification
The checker watches every cycle for the following:
- `start` clears the state one cycle later.
- `busy` and `done` are never high together.
- `count` never decreases and rises by at most one per cycle during a run.
- `count` is frozen while idle.
- `count` holds at saturation.
- `overflow` stays set until the next start.

The exact results need the bench's reference model and its scenarios. These cover the window length for each gate code, the divide-by-two on the high-frequency input, period values and timeouts, and a configuration write ignored during a run.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  typedef enum logic [1:0] {
    GATE_1MS  = 2'd0,
    GATE_4MS  = 2'd1,
    GATE_8MS  = 2'd2,
    GATE_32MS = 2'd3
  } gate_e;

  typedef struct packed {
    logic  use_lf;
    logic  period;
    gate_e gate;
  } ucnt_cfg_t;

  localparam int unsigned WIN_MS_W = 6;

  function automatic logic [WIN_MS_W-1:0] gate_len_ms(gate_e g);
    case (g)
      GATE_1MS:  return WIN_MS_W'(1);
      GATE_4MS:  return WIN_MS_W'(4);
      GATE_8MS:  return WIN_MS_W'(8);
      default:   return WIN_MS_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/ucnt_edge.sv
module ucnt_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ucnt_gate.sv
module ucnt_gate #(
  parameter int unsigned CLK_PER_MS = 4500,
  parameter int unsigned MS_W       = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic [MS_W-1:0] len_ms,
  output logic            win_end
);
  localparam int unsigned PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             tick;

  assign tick    = run & (pre_q == PRE_LAST);
  assign win_end = tick & (ms_q == (len_ms - MS_W'(1)));

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (clr) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (run) begin
      if (tick) begin
        pre_d = '0;
        ms_d  = ms_q + MS_W'(1);
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end
endmodule

// File: rtl/universal_counter.sv
module universal_counter
  import ucnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned CLK_PER_MS  = 4500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hf_in,
  input  logic             lf_in,
  input  logic             cfg_we,
  input  logic             cfg_use_lf,
  input  logic             cfg_period,
  input  logic [1:0]       cfg_gate,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int unsigned      N_IN    = 2;

  // index 0: high-frequency input, index 1: low-frequency input
  logic [N_IN-1:0] raw_in, rise;
  assign raw_in = {lf_in, hf_in};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    ucnt_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[i]),
      .rise (rise[i])
    );
  end

  ucnt_cfg_t        cfg_q, cfg_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic             ovf_q, ovf_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_q, div_d;
  logic             arm_q, arm_d;
  logic             win_end;

  ucnt_gate #(.CLK_PER_MS(CLK_PER_MS), .MS_W(WIN_MS_W)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .run    (run_q),
    .len_ms (gate_len_ms(cfg_q.gate)),
    .win_end(win_end)
  );

  logic inc, close_edge, arm_edge, finish, timeout, hf_step;

  always_comb begin
    hf_step    = run_q & ~cfg_q.period & ~cfg_q.use_lf & rise[0];
    arm_edge   = run_q & cfg_q.period & ~arm_q & rise[1];
    close_edge = run_q & cfg_q.period & arm_q & rise[1];
    timeout    = run_q & cfg_q.period & win_end & ~close_edge;
    finish     = run_q & (close_edge | win_end);
    if (!run_q)             inc = 1'b0;
    else if (cfg_q.period)  inc = arm_q;
    else if (cfg_q.use_lf)  inc = rise[1];
    else                    inc = hf_step & div_q;
  end

  always_comb begin
    cfg_d  = cfg_q;
    run_d  = run_q;
    done_d = done_q;
    ovf_d  = ovf_q;
    cnt_d  = cnt_q;
    div_d  = div_q;
    arm_d  = arm_q;
    if (cfg_we && !run_q) begin
      cfg_d.use_lf = cfg_use_lf;
      cfg_d.period = cfg_period;
      cfg_d.gate   = gate_e'(cfg_gate);
    end
    if (start) begin
      run_d  = 1'b1;
      done_d = 1'b0;
      ovf_d  = 1'b0;
      cnt_d  = '0;
      div_d  = 1'b0;
      arm_d  = 1'b0;
    end else begin
      if (inc) begin
        if (cnt_q == CNT_MAX) ovf_d = 1'b1;
        else                  cnt_d = cnt_q + CNT_W'(1);
      end
      if (hf_step)  div_d = ~div_q;
      if (arm_edge) arm_d = 1'b1;
      if (timeout)  ovf_d = 1'b1;
      if (finish) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{use_lf: 1'b0, period: 1'b0, gate: GATE_1MS};
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      run_q  <= run_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      arm_q  <= arm_d;
    end
  end

  assign busy     = run_q;
  assign done     = done_q;
  assign overflow = ovf_q;
  assign count    = cnt_q;
endmodule

// File: rtl/ucnt_checker.sv
module ucnt_checker #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             overflow,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && !overflow && count == '0));

  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_frozen_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(count));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  p_saturate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !start) |=> count == CNT_MAX);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow);
endmodule

bind universal_counter ucnt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .overflow(overflow),
  .count   (count)
);

// File: tb/sim_universal_counter.sv
module sim_universal_counter;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned P     = 20;
  localparam int          MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hf_in = 1'b0, lf_in = 1'b0;
  logic cfg_we = 1'b0, cfg_use_lf = 1'b0, cfg_period = 1'b0;
  logic [1:0] cfg_gate = 2'd0;
  logic start = 1'b0;
  logic busy, done, overflow;
  logic [CNT_W-1:0] count;

  always #2 clk = ~clk;

  universal_counter #(.CNT_W(CNT_W), .CLK_PER_MS(P), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hf_in(hf_in), .lf_in(lf_in),
    .cfg_we(cfg_we), .cfg_use_lf(cfg_use_lf), .cfg_period(cfg_period),
    .cfg_gate(cfg_gate), .start(start),
    .busy(busy), .done(done), .overflow(overflow), .count(count)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // input waveform generators (half period in cycles, 0 = hold)
  int hf_half = 0, lf_half = 0, hf_ph = 0, lf_ph = 0;
  always @(negedge clk) begin
    if (hf_half > 0) begin
      hf_ph++;
      if (hf_ph >= hf_half) begin hf_in <= ~hf_in; hf_ph = 0; end
    end
    if (lf_half > 0) begin
      lf_ph++;
      if (lf_ph >= lf_half) begin lf_in <= ~lf_in; lf_ph = 0; end
    end
  end

  // behavioural reference model
  int m_cnt;
  bit m_run, m_done, m_ovf, m_div, m_arm, m_use_lf, m_period;
  int m_gate, m_el;
  bit hq[3], lq[3];

  function automatic int win_ms(int g);
    case (g) 0: return 1; 1: return 4; 2: return 8; default: return 32; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_done = 0; m_ovf = 0; m_div = 0; m_arm = 0;
      m_use_lf = 0; m_period = 0; m_gate = 0; m_el = 0;
      for (int i = 0; i < 3; i++) begin hq[i] = 0; lq[i] = 0; end
    end else begin
      bit r_hf, r_lf, was_run, incr, wend, closing;
      r_hf = hq[1] && !hq[2];
      r_lf = lq[1] && !lq[2];
      hq[2] = hq[1]; hq[1] = hq[0]; hq[0] = hf_in;
      lq[2] = lq[1]; lq[1] = lq[0]; lq[0] = lf_in;
      was_run = m_run;
      if (start) begin
        m_run = 1; m_done = 0; m_ovf = 0; m_cnt = 0; m_div = 0; m_arm = 0; m_el = 0;
      end else if (m_run) begin
        wend = (m_el == win_ms(m_gate) * P - 1);
        m_el++;
        incr = 0; closing = 0;
        if (m_period) begin
          if (m_arm) begin incr = 1; closing = r_lf; end
          else if (r_lf) m_arm = 1;
        end else if (m_use_lf) incr = r_lf;
        else if (r_hf) begin incr = m_div; m_div = !m_div; end
        if (incr) begin
          if (m_cnt == MAXV) m_ovf = 1; else m_cnt++;
        end
        if (m_period && wend && !closing) m_ovf = 1;
        if (closing || wend) begin m_run = 0; m_done = 1; end
      end
      if (cfg_we && !was_run) begin
        m_use_lf = cfg_use_lf; m_period = cfg_period; m_gate = cfg_gate;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 busy", busy, m_run);
      chk("R6 done", done, m_done);
      chk("R7 overflow", overflow, m_ovf);
      chk("R2 count", count, m_cnt);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic write_cfg(bit use_lf, bit period, int gate);
    @(negedge clk);
    cfg_we = 1; cfg_use_lf = use_lf; cfg_period = period; cfg_gate = 2'(gate);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle(string tag);
    int n = 0;
    while (busy) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin
        miscompares++;
        $display("FAIL %s watchdog actual=%0d expected=%0d", tag, n, 5000);
        break;
      end
    end
    @(negedge clk);
  endtask

  task automatic run_meas(string tag, int exp_cnt, int exp_ovf);
    pulse_start();
    wait_idle(tag);
    chk(tag, count, exp_cnt);
    chk(tag, overflow, exp_ovf);
    chk(tag, done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 count", count, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1, R3: default config = HF freq 1 ms; HF rises every 2 cycles -> 10 rises -> 5
    hf_half = 1;
    repeat (10) @(negedge clk);
    run_meas("R1_R3 default hf", 5, 0);

    // R2: LF frequency, period 4 cycles, each gate code
    lf_half = 2;
    write_cfg(1, 0, 1); run_meas("R2 gate4", 20, 0);
    write_cfg(1, 0, 2); run_meas("R2 gate8", 40, 0);
    write_cfg(1, 0, 3); run_meas("R2 gate32", 160, 0);
    write_cfg(1, 0, 0); run_meas("R2 gate1", 5, 0);

    // R3: HF on 8 ms with period 2 -> 80 rises -> 40
    write_cfg(0, 0, 2); run_meas("R3 hf gate8", 40, 0);

    // R4: period of 14 cycles, LF selected and HF selected
    lf_half = 7;
    write_cfg(1, 1, 3); run_meas("R4 period lf", 14, 0);
    write_cfg(0, 1, 3); run_meas("R4 period ignores select", 14, 0);

    // R7: period beyond counter range saturates
    lf_half = 150;
    write_cfg(1, 1, 3); run_meas("R7 period sat", MAXV, 1);

    // R7: frequency saturation
    lf_half = 1;
    write_cfg(1, 0, 3); run_meas("R7 freq sat", MAXV, 1);

    // R5: no LF edges in period mode -> timeout
    lf_half = 0;
    write_cfg(1, 1, 0); run_meas("R5 timeout", 0, 1);

    // R6: result frozen after done
    repeat (40) @(negedge clk);
    chk("R6 frozen count", count, 0);
    chk("R6 done held", done, 1);
    chk("R6 busy low", busy, 0);

    // R8: restart while busy
    lf_half = 2;
    write_cfg(1, 0, 3);
    pulse_start();
    repeat (100) @(negedge clk);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R8 count cleared", count, 0);
    chk("R8 busy", busy, 1);
    chk("R8 done clear", done, 0);
    wait_idle("R8");
    chk("R8 full window after restart", count, 160);

    // R9: config write while busy ignored
    write_cfg(1, 0, 0);
    pulse_start();
    write_cfg(0, 1, 3);
    wait_idle("R9 first");
    chk("R9 first", count, 5);
    run_meas("R9 cfg kept", 5, 0);

    summary();
  end
endmodule